// File: doc/BRIEF.md
# Quadrature Encoder Counter Channel

This block is one 24-bit up/down position counter for a rotary or linear encoder. Phase inputs A and B and an index input come in from outside the chip. They are resynchronised, sampled on a filter clock divided down by a programmable prescaler, and decoded in one of four ways: pulse-plus-direction, or quadrature at one, two or four counts per cycle. Four count modes shape what happens at the ends of the range: free wrap, clamp, halt after a wrap, and modulo a programmed ceiling. Toggle flags record wraps above and below the range, so a reader can rebuild a 25-bit extended count from borrow XOR carry.

A host reaches the channel through an 8-bit bus with two ports. On the data port, writes fill a preset register and reads drain an output latch. Both move one byte per access, least significant first, under a shared byte pointer. On the control port, a write is a command byte whose top three bits pick one of four internal registers. A read of the control port returns the status flags. The index input can reload the counter from the preset. A single event output pulses for a selectable condition.

Top module: `qcc_top`

## Requirements
- R1: After reset the counter reads 0 and a control-port read returns 0x20: borrow toggle bit 0 = 0, carry toggle bit 1 = 0, noise bit 4 = 0, direction bit 5 = 1 (up). Control-write bits 7:5 select the target: 000 command, 001 mode, 010 input/output, 011 index.
- R2: Data-port writes load preset bytes 0,1,2 and data-port reads return latch bytes 0,1,2, with the byte pointer stepping 0,1,2,0. A command bit 0 returns the pointer to 0. Command field bits 4:3 = 01 copies the preset into the counter, and = 10 copies the counter into the latch.
- R3: Command field bits 2:1 = 01 zeroes the counter, = 10 clears both toggle flags, and = 11 clears the noise flag.
- R4: With mode bits 4:3 = 00 (pulse/direction), each rising A edge counts once. The direction is up when B is low and down when B is high, and a change of B alone does not count.
- R5: Mode bits 4:3 = 01/10/11 select quadrature x1/x2/x4. The up sequence of {A,B} is 00,10,11,01. x1 counts A rising going up and A falling going down. x2 counts every A edge, and x4 counts every A or B edge. The direction flag follows the last counted step.
- R6: Mode bits 2:1 = 00 (normal) wraps 0xFFFFFF to 0 going up, flipping the carry toggle, and wraps 0 to 0xFFFFFF going down, flipping the borrow toggle.
- R7: Mode bits 2:1 = 01 (range limit) holds the count at the preset going up and at 0 going down, without touching the toggles.
- R8: Mode bits 2:1 = 10 (non-recycle) wraps like normal mode, then ignores steps until the counter is zeroed or loaded from the preset.
- R9: Mode bits 2:1 = 11 (modulo-N) goes from the preset to 0 going up (carry flips) and from 0 to the preset going down (borrow flips).
- R10: Input/output bit 0 = 0 disables A/B, and encoder movement then changes neither the count nor the flags.
- R11: A and B changing in the same filter sample sets the noise flag and that sample does not count.
- R12: Input/output bit 1 = 0 makes an index event load the preset into the counter. Index bit 1 = 1 makes the event a rising index edge, and 0 makes it a falling edge.
- R13: Index bit 0 = 1 (synchronous) makes the index count only on a filter sample where A and B are both low. It is accepted only in a quadrature mode, and selecting pulse/direction clears it.
- R14: Command field bits 4:3 = 11 loads preset byte 0 as the prescaler P and restarts the divider, so a filter sample is taken every P+1 clocks. Input/output bits 4:3 pick the event output pulse: 0 carry wrap, 1 step onto the preset, 2 carry or borrow wrap, 3 index event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ctl | input | 1 | Port select: 1 control/flags, 0 data |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered on the strobe edge |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B or direction (asynchronous) |
| enc_idx | input | 1 | Encoder index (asynchronous) |
| evt_flag | output | 1 | One-cycle pulse for the selected event |

## Verification
Most internal state is visible only through the flag byte and the latched count. A wrong decode or count-mode choice therefore shows as a wrong count in the next latch read, which comes a few cycles after the encoder edge has passed the synchronizer, the filter sample and the decoder register. A wrong toggle or noise flag shows in the next control-port read. A missing halt, a missing clamp or a wrong byte pointer only shows once the step or access that follows is made. For that reason, the checks on these cases always drive one more step or one more byte after the boundary.

// File: rtl/qcc_pkg.sv
package qcc_pkg;

    typedef enum logic [1:0] {
        CM_NORMAL    = 2'd0,
        CM_RANGE     = 2'd1,
        CM_NORECYCLE = 2'd2,
        CM_MODULO    = 2'd3
    } count_mode_e;

    typedef enum logic [1:0] {
        DM_PULSE = 2'd0,
        DM_X1    = 2'd1,
        DM_X2    = 2'd2,
        DM_X4    = 2'd3
    } dec_mode_e;

    typedef enum logic [1:0] {
        FF_CARRY        = 2'd0,
        FF_MATCH        = 2'd1,
        FF_CARRY_BORROW = 2'd2,
        FF_INDEX        = 2'd3
    } flag_fn_e;

    typedef enum logic [2:0] {
        RS_CMD   = 3'd0,
        RS_MODE  = 3'd1,
        RS_IO    = 3'd2,
        RS_INDEX = 3'd3
    } reg_sel_e;

    typedef struct packed {
        logic valid;
        logic up;
    } step_t;

    // Classify one filter sample transition for the selected decode mode.
    function automatic step_t decode_step(dec_mode_e m, logic pa, logic pb,
                                          logic na, logic nb);
        step_t s;
        logic  a_chg, b_chg, q_up;
        a_chg = pa ^ na;
        b_chg = pb ^ nb;
        q_up  = a_chg ? (na != nb) : (na == nb);
        s.valid = 1'b0;
        s.up    = q_up;
        case (m)
            DM_PULSE: begin
                s.valid = a_chg & na & ~b_chg;
                s.up    = ~nb;
            end
            DM_X1: s.valid = a_chg & ~b_chg & (q_up ? na : ~na);
            DM_X2: s.valid = a_chg & ~b_chg;
            DM_X4: s.valid = a_chg ^ b_chg;
            default: s.valid = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/qcc_input_filter.sv
module qcc_input_filter #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a_i,
    input  logic             b_i,
    input  logic             idx_i,
    input  logic [PSC_W-1:0] psc_i,
    input  logic             restart_i,
    output logic             tick_o,
    output logic             a_new_o,
    output logic             b_new_o,
    output logic             a_old_o,
    output logic             b_old_o,
    output logic             idx_new_o,
    output logic             idx_old_o,
    output logic             idx_lvl_o,
    output logic             idx_lvl_d_o
);
    localparam int NSYNC = 2;

    logic [NSYNC-1:0] a_sy, b_sy, i_sy;
    logic [PSC_W-1:0] div_q;
    logic             tick;

    assign tick = !restart_i && (div_q == psc_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_sy        <= '0;
            b_sy        <= '0;
            i_sy        <= '0;
            div_q       <= '0;
            tick_o      <= 1'b0;
            a_new_o     <= 1'b0;
            b_new_o     <= 1'b0;
            a_old_o     <= 1'b0;
            b_old_o     <= 1'b0;
            idx_new_o   <= 1'b0;
            idx_old_o   <= 1'b0;
            idx_lvl_d_o <= 1'b0;
        end else begin
            a_sy        <= {a_sy[NSYNC-2:0], a_i};
            b_sy        <= {b_sy[NSYNC-2:0], b_i};
            i_sy        <= {i_sy[NSYNC-2:0], idx_i};
            idx_lvl_d_o <= i_sy[NSYNC-1];
            if (restart_i || tick) div_q <= '0;
            else                   div_q <= div_q + 1'b1;
            tick_o <= tick;
            if (tick) begin
                a_new_o   <= a_sy[NSYNC-1];
                b_new_o   <= b_sy[NSYNC-1];
                idx_new_o <= i_sy[NSYNC-1];
                a_old_o   <= a_new_o;
                b_old_o   <= b_new_o;
                idx_old_o <= idx_new_o;
            end
        end
    end

    assign idx_lvl_o = i_sy[NSYNC-1];

    // R14: a filter sample never follows a prescaler restart directly
    a_r14_restart_no_tick: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> !tick_o);

endmodule

// File: rtl/qcc_step_decoder.sv
module qcc_step_decoder
    import qcc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      evt_i,
    input  logic      en_i,
    input  dec_mode_e mode_i,
    input  logic      a_old_i,
    input  logic      b_old_i,
    input  logic      a_new_i,
    input  logic      b_new_i,
    output step_t     step_o,
    output logic      noise_o
);
    logic  both_chg;
    step_t raw;

    assign both_chg = (a_old_i ^ a_new_i) & (b_old_i ^ b_new_i);
    assign raw      = decode_step(mode_i, a_old_i, b_old_i, a_new_i, b_new_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_o  <= '0;
            noise_o <= 1'b0;
        end else if (evt_i && en_i) begin
            noise_o      <= both_chg;
            step_o.valid <= raw.valid & ~both_chg;
            step_o.up    <= raw.up;
        end else begin
            noise_o      <= 1'b0;
            step_o.valid <= 1'b0;
            step_o.up    <= step_o.up;
        end
    end

    // R11: a noisy sample never produces a count step
    a_r11_noise_no_step: assert property (@(posedge clk) disable iff (rst)
        !(noise_o && step_o.valid));

endmodule

// File: rtl/qcc_count_core.sv
module qcc_count_core
    import qcc_pkg::*;
#(
    parameter int W = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  step_t       step_i,
    input  count_mode_e mode_i,
    input  logic [W-1:0] preset_i,
    input  logic        clear_i,
    input  logic        load_i,
    input  logic        clear_flags_i,
    output logic [W-1:0] count_o,
    output logic        bt_o,
    output logic        ct_o,
    output logic        dir_o,
    output logic        carry_o,
    output logic        borrow_o,
    output logic        match_o
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] cnt_q, nxt;
    logic         halted_q, accept, wrap_up, wrap_dn, override;

    assign override = clear_i | load_i;
    assign accept   = step_i.valid && !(mode_i == CM_NORECYCLE && halted_q);

    always_comb begin
        nxt     = cnt_q;
        wrap_up = 1'b0;
        wrap_dn = 1'b0;
        if (accept) begin
            if (step_i.up) begin
                case (mode_i)
                    CM_RANGE:  nxt = (cnt_q >= preset_i) ? cnt_q : cnt_q + 1'b1;
                    CM_MODULO: begin
                        if (cnt_q >= preset_i) begin
                            nxt     = '0;
                            wrap_up = 1'b1;
                        end else nxt = cnt_q + 1'b1;
                    end
                    default: begin
                        wrap_up = (cnt_q == MAXV);
                        nxt     = cnt_q + 1'b1;
                    end
                endcase
            end else begin
                case (mode_i)
                    CM_RANGE:  nxt = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
                    CM_MODULO: begin
                        if (cnt_q == '0) begin
                            nxt     = preset_i;
                            wrap_dn = 1'b1;
                        end else nxt = cnt_q - 1'b1;
                    end
                    default: begin
                        wrap_dn = (cnt_q == '0);
                        nxt     = cnt_q - 1'b1;
                    end
                endcase
            end
        end
    end

    assign carry_o  = wrap_up & ~override;
    assign borrow_o = wrap_dn & ~override;
    assign match_o  = accept & ~override & (nxt == preset_i) & (nxt != cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            halted_q <= 1'b0;
            bt_o     <= 1'b0;
            ct_o     <= 1'b0;
            dir_o    <= 1'b1;
        end else begin
            if (clear_i) begin
                cnt_q    <= '0;
                halted_q <= 1'b0;
            end else if (load_i) begin
                cnt_q    <= preset_i;
                halted_q <= 1'b0;
            end else if (accept) begin
                cnt_q <= nxt;
                dir_o <= step_i.up;
                if (mode_i == CM_NORECYCLE && (wrap_up || wrap_dn))
                    halted_q <= 1'b1;
            end
            if (clear_flags_i) begin
                bt_o <= 1'b0;
                ct_o <= 1'b0;
            end else begin
                if (carry_o)  ct_o <= ~ct_o;
                if (borrow_o) bt_o <= ~bt_o;
            end
        end
    end

    assign count_o = cnt_q;

    // R6: an up step at the top in normal mode lands on zero and flips carry
    a_r6_wrap_up: assert property (@(posedge clk) disable iff (rst)
        (mode_i == CM_NORMAL && step_i.valid && step_i.up && cnt_q == MAXV
         && !override && !clear_flags_i)
        |=> (cnt_q == '0 && ct_o != $past(ct_o)));

    // R7: range limit never moves past the ceiling
    a_r7_range_hold: assert property (@(posedge clk) disable iff (rst)
        (mode_i == CM_RANGE && step_i.valid && step_i.up && cnt_q >= preset_i
         && !override) |=> (cnt_q == $past(cnt_q)));

    // R8: once halted, non-recycle ignores steps
    a_r8_halt_holds: assert property (@(posedge clk) disable iff (rst)
        (mode_i == CM_NORECYCLE && halted_q && !override)
        |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/qcc_top.sv
module qcc_top
    import qcc_pkg::*;
#(
    parameter int W     = 24,
    parameter int PSC_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_ctl,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       enc_a,
    input  logic       enc_b,
    input  logic       enc_idx,
    output logic       evt_flag
);
    localparam int NBYTES = W / 8;
    localparam int BP_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [BP_W-1:0] BP_LAST = BP_W'(NBYTES - 1);

    // configuration state
    count_mode_e cmode_q;
    dec_mode_e   dmode_q;
    flag_fn_e    ffn_q;
    logic        ab_en_q, pre_idx_n_q, sync_q, pol_q, err_q;
    logic [PSC_W-1:0] psc_q;
    logic [NBYTES-1:0][7:0] preset_q, latch_q;
    logic [BP_W-1:0] bp_q;

    // bus decode
    logic       wr_ctl, wr_dat, rd_ctl, rd_dat;
    logic       is_cmd;
    logic [4:0] pay;
    logic       clr_cnt, clr_flg, clr_err, ld_pre, to_latch, to_psc;

    assign wr_ctl   = bus_wr &  bus_ctl;
    assign wr_dat   = bus_wr & ~bus_ctl;
    assign rd_ctl   = bus_rd &  bus_ctl;
    assign rd_dat   = bus_rd & ~bus_ctl;
    assign pay      = bus_wdata[4:0];
    assign is_cmd   = wr_ctl && (reg_sel_e'(bus_wdata[7:5]) == RS_CMD);
    assign clr_cnt  = is_cmd && pay[2:1] == 2'b01;
    assign clr_flg  = is_cmd && pay[2:1] == 2'b10;
    assign clr_err  = is_cmd && pay[2:1] == 2'b11;
    assign ld_pre   = is_cmd && pay[4:3] == 2'b01;
    assign to_latch = is_cmd && pay[4:3] == 2'b10;
    assign to_psc   = is_cmd && pay[4:3] == 2'b11;

    // sampling front end
    logic tick, a_new, b_new, a_old, b_old, i_new, i_old, i_lvl, i_lvl_d;

    qcc_input_filter #(.PSC_W(PSC_W)) u_filter (
        .clk(clk), .rst(rst), .a_i(enc_a), .b_i(enc_b), .idx_i(enc_idx),
        .psc_i(psc_q), .restart_i(to_psc), .tick_o(tick),
        .a_new_o(a_new), .b_new_o(b_new), .a_old_o(a_old), .b_old_o(b_old),
        .idx_new_o(i_new), .idx_old_o(i_old),
        .idx_lvl_o(i_lvl), .idx_lvl_d_o(i_lvl_d)
    );

    step_t step;
    logic  noise;

    qcc_step_decoder u_dec (
        .clk(clk), .rst(rst), .evt_i(tick), .en_i(ab_en_q), .mode_i(dmode_q),
        .a_old_i(a_old), .b_old_i(b_old), .a_new_i(a_new), .b_new_i(b_new),
        .step_o(step), .noise_o(noise)
    );

    // index event
    logic idx_async, idx_sync, idx_evt;
    assign idx_async = pol_q ? (i_lvl & ~i_lvl_d) : (~i_lvl & i_lvl_d);
    assign idx_sync  = tick & ~a_new & ~b_new &
                       (pol_q ? (i_new & ~i_old) : (~i_new & i_old));
    assign idx_evt   = sync_q ? idx_sync : idx_async;

    // counter
    logic [W-1:0] count;
    logic bt, ct, dir, carry, borrow, match;

    qcc_count_core #(.W(W)) u_core (
        .clk(clk), .rst(rst), .step_i(step), .mode_i(cmode_q),
        .preset_i(preset_q), .clear_i(clr_cnt),
        .load_i(ld_pre | (idx_evt & ~pre_idx_n_q)),
        .clear_flags_i(clr_flg), .count_o(count), .bt_o(bt), .ct_o(ct),
        .dir_o(dir), .carry_o(carry), .borrow_o(borrow), .match_o(match)
    );

    // registers and bus
    always_ff @(posedge clk) begin
        if (rst) begin
            cmode_q     <= CM_NORMAL;
            dmode_q     <= DM_PULSE;
            ffn_q       <= FF_CARRY;
            ab_en_q     <= 1'b0;
            pre_idx_n_q <= 1'b1;
            sync_q      <= 1'b0;
            pol_q       <= 1'b1;
            err_q       <= 1'b0;
            psc_q       <= '0;
            preset_q    <= '0;
            latch_q     <= '0;
            bp_q        <= '0;
            bus_rdata   <= '0;
            evt_flag    <= 1'b0;
        end else begin
            if (is_cmd && pay[0])
                bp_q <= '0;
            else if (wr_dat || rd_dat)
                bp_q <= (bp_q == BP_LAST) ? '0 : bp_q + 1'b1;

            if (wr_dat) preset_q[bp_q] <= bus_wdata;
            if (rd_dat) bus_rdata <= latch_q[bp_q];
            if (rd_ctl) bus_rdata <= {2'b00, dir, err_q, 2'b00, ct, bt};

            if (to_latch) latch_q <= count;
            if (to_psc)   psc_q   <= preset_q[0][PSC_W-1:0];

            if (noise)        err_q <= 1'b1;
            else if (clr_err) err_q <= 1'b0;

            if (wr_ctl) begin
                case (reg_sel_e'(bus_wdata[7:5]))
                    RS_MODE: begin
                        cmode_q <= count_mode_e'(bus_wdata[2:1]);
                        dmode_q <= dec_mode_e'(bus_wdata[4:3]);
                        if (dec_mode_e'(bus_wdata[4:3]) == DM_PULSE) sync_q <= 1'b0;
                    end
                    RS_IO: begin
                        ab_en_q     <= bus_wdata[0];
                        pre_idx_n_q <= bus_wdata[1];
                        ffn_q       <= flag_fn_e'(bus_wdata[4:3]);
                    end
                    RS_INDEX: begin
                        sync_q <= bus_wdata[0] & (dmode_q != DM_PULSE);
                        pol_q  <= bus_wdata[1];
                    end
                    default: ;
                endcase
            end

            case (ffn_q)
                FF_CARRY:        evt_flag <= carry;
                FF_MATCH:        evt_flag <= match;
                FF_CARRY_BORROW: evt_flag <= carry | borrow;
                default:         evt_flag <= idx_evt;
            endcase
        end
    end

    // R2: the byte pointer stays inside the register width
    a_r2_bp_range: assert property (@(posedge clk) disable iff (rst)
        bp_q <= BP_LAST);

    // R11: a noisy sample raises the noise flag on the following cycle
    a_r11_noise_sets_err: assert property (@(posedge clk) disable iff (rst)
        noise |=> err_q);

    // R13: synchronous index only coexists with a quadrature mode
    a_r13_sync_needs_quad: assert property (@(posedge clk) disable iff (rst)
        sync_q |-> (dmode_q != DM_PULSE));

    // R10: with A/B disabled for two cycles no step reaches the counter
    a_r10_disabled_no_step: assert property (@(posedge clk) disable iff (rst)
        (!ab_en_q && !$past(ab_en_q)) |-> !step.valid);

endmodule

// File: tb/tb_qcc_top.sv
`timescale 1ns/1ps
module tb_qcc_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_ctl = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
    logic       evt_flag;

    int n_chk = 0, n_bad = 0, pulses = 0;
    logic qa = 1'b0, qb = 1'b0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    qcc_top dut (
        .clk(clk), .rst(rst), .bus_ctl(bus_ctl), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx), .evt_flag(evt_flag)
    );

    always @(negedge clk) if (!rst && evt_flag) pulses++;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr_ctl(logic [7:0] d);
        @(negedge clk); bus_ctl = 1'b1; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic wr_dat(logic [7:0] d);
        @(negedge clk); bus_ctl = 1'b0; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(logic c, output logic [7:0] d);
        @(negedge clk); bus_ctl = c; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic set_preset(logic [23:0] v);
        wr_ctl(8'h01);
        wr_dat(v[7:0]); wr_dat(v[15:8]); wr_dat(v[23:16]);
    endtask

    task automatic load_count(logic [23:0] v);
        set_preset(v);
        wr_ctl(8'h08);
    endtask

    task automatic read_count(output logic [23:0] v);
        logic [7:0] b0, b1, b2;
        wr_ctl(8'h11);
        rd(1'b0, b0); rd(1'b0, b1); rd(1'b0, b2);
        v = {b2, b1, b0};
    endtask

    task automatic flags(output logic [7:0] f);
        rd(1'b1, f);
    endtask

    task automatic enc(logic a, logic b);
        @(negedge clk); enc_a = a; enc_b = b; qa = a; qb = b;
        repeat (7) @(negedge clk);
    endtask

    task automatic qstep(logic up);
        logic [1:0] s, n;
        s = {qa, qb};
        if (up) case (s) 2'b00: n = 2'b10; 2'b10: n = 2'b11; 2'b11: n = 2'b01; default: n = 2'b00; endcase
        else    case (s) 2'b00: n = 2'b01; 2'b01: n = 2'b11; 2'b11: n = 2'b10; default: n = 2'b00; endcase
        enc(n[1], n[0]);
    endtask

    task automatic idx_pulse();
        @(negedge clk); enc_idx = 1'b1; repeat (6) @(negedge clk);
        enc_idx = 1'b0; repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] v, mcnt;
        logic [7:0]  f, b;
        logic        mbt, mct, mdir;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        flags(f);      chk("R1 reset flags", f, 8'h20);
        read_count(v); chk("R1 reset count", v, 24'h0);

        // R2 preset / latch byte order and pointer wrap
        load_count(24'hA5C312);
        read_count(v); chk("R2 preset to counter", v, 24'hA5C312);
        rd(1'b0, b);   chk("R2 pointer wraps to byte 0", b, 8'h12);

        // R3 clear counter
        wr_ctl(8'h02);
        read_count(v); chk("R3 clear counter", v, 24'h0);

        // R4 pulse/direction
        wr_ctl(8'h43);
        repeat (3) begin enc(1, 0); enc(0, 0); end
        read_count(v); chk("R4 up pulses", v, 24'd3);
        enc(0, 1);
        read_count(v); chk("R4 B alone no count", v, 24'd3);
        repeat (2) begin enc(1, 1); enc(0, 1); end
        read_count(v); chk("R4 down pulses", v, 24'd1);
        flags(f);      chk("R4 direction down", f, 8'h00);

        // R5 quadrature scales
        wr_ctl(8'h28); wr_ctl(8'h02);
        repeat (4) qstep(1);
        read_count(v); chk("R5 x1 up cycle", v, 24'd1);
        repeat (4) qstep(0);
        read_count(v); chk("R5 x1 down cycle", v, 24'd0);
        flags(f);      chk("R5 x1 direction down", f, 8'h00);
        wr_ctl(8'h30);
        repeat (4) qstep(1);
        read_count(v); chk("R5 x2 up cycle", v, 24'd2);
        wr_ctl(8'h38);
        repeat (4) qstep(1);
        read_count(v); chk("R5 x4 up cycle", v, 24'd6);
        flags(f);      chk("R5 direction up", f, 8'h20);

        // R6 normal wrap and toggles
        load_count(24'hFFFFFE);
        repeat (3) qstep(1);
        read_count(v); chk("R6 wrap up", v, 24'd1);
        flags(f);      chk("R6 carry toggled", f, 8'h22);
        repeat (2) qstep(0);
        read_count(v); chk("R6 wrap down", v, 24'hFFFFFF);
        flags(f);      chk("R6 borrow toggled", f, 8'h03);
        wr_ctl(8'h04);
        flags(f);      chk("R3 clear toggles", f, 8'h00);

        // R7 range limit
        set_preset(24'd5); wr_ctl(8'h3A); wr_ctl(8'h02);
        repeat (8) qstep(1);
        read_count(v); chk("R7 hold at ceiling", v, 24'd5);
        repeat (7) qstep(0);
        read_count(v); chk("R7 hold at zero", v, 24'd0);
        flags(f);      chk("R7 toggles untouched", f, 8'h00);

        // R8 non-recycle
        wr_ctl(8'h3C); load_count(24'hFFFFFE);
        repeat (3) qstep(1);
        read_count(v); chk("R8 halted after wrap", v, 24'd0);
        repeat (2) qstep(1);
        read_count(v); chk("R8 still halted", v, 24'd0);
        wr_ctl(8'h02);
        repeat (2) qstep(1);
        read_count(v); chk("R8 resumes after clear", v, 24'd2);
        wr_ctl(8'h04);

        // R9 modulo-N
        set_preset(24'd3); wr_ctl(8'h3E); wr_ctl(8'h02);
        repeat (5) qstep(1);
        read_count(v); chk("R9 modulo up", v, 24'd1);
        repeat (3) qstep(0);
        read_count(v); chk("R9 modulo down", v, 24'd2);
        flags(f);      chk("R9 both toggles", f, 8'h03);
        wr_ctl(8'h04);

        // R10 A/B disable
        wr_ctl(8'h38); wr_ctl(8'h02); wr_ctl(8'h42);
        repeat (4) qstep(1);
        read_count(v); chk("R10 disabled no count", v, 24'd0);
        flags(f);      chk("R10 disabled no flags", f, 8'h00);
        wr_ctl(8'h43);
        qstep(1);
        read_count(v); chk("R10 re-enabled count", v, 24'd1);

        // R11 noise
        enc(~qa, ~qb);
        read_count(v); chk("R11 noisy sample ignored", v, 24'd1);
        flags(f);      chk("R11 noise flag", f & 8'h10, 8'h10);
        wr_ctl(8'h06);
        flags(f);      chk("R3 clear noise flag", f & 8'h10, 8'h00);

        // R12 preset on index, polarity
        set_preset(24'h123456); wr_ctl(8'h41); wr_ctl(8'h62); wr_ctl(8'h02);
        idx_pulse();
        read_count(v); chk("R12 positive index load", v, 24'h123456);
        wr_ctl(8'h60); wr_ctl(8'h02);
        @(negedge clk); enc_idx = 1'b1; repeat (6) @(negedge clk);
        read_count(v); chk("R12 negative ignores rise", v, 24'h0);
        enc_idx = 1'b0; repeat (6) @(negedge clk);
        read_count(v); chk("R12 negative loads on fall", v, 24'h123456);
        wr_ctl(8'h43); wr_ctl(8'h02);
        idx_pulse();
        read_count(v); chk("R12 disabled no load", v, 24'h0);

        // R13 synchronous index
        wr_ctl(8'h38); wr_ctl(8'h41); wr_ctl(8'h63);
        while ({qa, qb} != 2'b10) qstep(1);
        wr_ctl(8'h02);
        idx_pulse();
        read_count(v); chk("R13 gated while A high", v, 24'h0);
        qstep(0);
        wr_ctl(8'h02);
        idx_pulse();
        read_count(v); chk("R13 loads with A,B low", v, 24'h123456);
        wr_ctl(8'h20); wr_ctl(8'h63);
        enc(1, 0);
        wr_ctl(8'h02);
        idx_pulse();
        read_count(v); chk("R13 sync dropped in pulse mode", v, 24'h123456);

        // R14 event output functions
        wr_ctl(8'h38); wr_ctl(8'h43); load_count(24'hFFFFFF);
        pulses = 0; qstep(1);
        chk("R14 carry event", pulses, 1);
        load_count(24'd3); set_preset(24'd5); wr_ctl(8'h4B);
        pulses = 0; repeat (2) qstep(1);
        chk("R14 match event", pulses, 1);
        wr_ctl(8'h53); wr_ctl(8'h02);
        pulses = 0; qstep(0);
        chk("R14 borrow event", pulses, 1);
        wr_ctl(8'h5B);
        pulses = 0; idx_pulse();
        chk("R14 index event", pulses, 1);
        read_count(v); chk("R12 index without load", v, 24'hFFFFFF);

        // R6 random walk against a model, normal x4
        wr_ctl(8'h43); wr_ctl(8'h38); load_count(24'hFFFFF0); wr_ctl(8'h04);
        mcnt = 24'hFFFFF0; mbt = 1'b0; mct = 1'b0; mdir = 1'b0;
        for (int i = 0; i < 80; i++) begin
            logic up;
            up = ($urandom % 10) < 7;
            qstep(up);
            mdir = up;
            if (up) begin if (mcnt == 24'hFFFFFF) mct = ~mct; mcnt = mcnt + 1; end
            else    begin if (mcnt == 24'h0)      mbt = ~mbt; mcnt = mcnt - 1; end
            if (i % 8 == 7) begin
                read_count(v); chk("R6 random count", v, mcnt);
                flags(f);      chk("R6 random flags", f, {2'b00, mdir, 3'b000, mct, mbt});
            end
        end

        // R14 prescaler
        read_count(mcnt);
        set_preset(24'd99); wr_ctl(8'h18);
        qstep(1); repeat (30) @(negedge clk);
        read_count(v); chk("R14 before slow sample", v, mcnt);
        repeat (150) @(negedge clk);
        read_count(v); chk("R14 after slow sample", v, mcnt + 24'd1);
        set_preset(24'd0); wr_ctl(8'h18);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule